// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block times the start-up of an asynchronous DRAM and then keeps its contents alive. Once reset is released it counts out the mandatory power-up quiet time, then asks the memory access controller for a burst of eight initialization refreshes. After that it raises a refresh request at an even rate, so that all rows are refreshed within the retention period. The refreshes are of the kind that use the device's internal row counter, so no row address is produced here.

Requests use a level request and a single-cycle acknowledge. When the controller is busy with user traffic, the refreshes that fall due are kept in a small owed counter. The request stays high while anything is owed. Once the owed count reaches a threshold, an urgency flag tells the controller to close its open page at once. If the counter is full and another refresh falls due, a sticky error flag is set. A ready flag tells user logic when normal accesses may begin. All timing is derived from a clock-frequency parameter. The shape of the strobe waveforms is left to the controller.

Top module: `dram_rfsh_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, `rfsh_req_o`, `rfsh_urgent_o`, `mem_ready_o` and `debt_err_o` are all 0.
- R2: The power-up wait is PW = ceil(CLK_HZ·PWRUP_US/10^6) cycles. `rfsh_req_o` stays 0 through the first PW−1 rising edges after reset is released and is 1 after edge PW.
- R3: During initialization, `rfsh_req_o` is held at 1 until INIT_REFRESHES (8) acknowledges have been taken. After the edge that takes the eighth, `rfsh_req_o` is 0 and `mem_ready_o` is 1.
- R4: An acknowledge that arrives while `rfsh_req_o` is 0 is ignored. It shortens neither the power-up wait nor the initialization burst, and it does not reduce the owed count.
- R5: After initialization, a refresh falls due every IV = floor(CLK_HZ·RETAIN_US/(10^6·ROWS)) cycles. The first one falls due IV edges after the edge on which `mem_ready_o` rose.
- R6: Each refresh that falls due adds one to the owed count, and each accepted acknowledge (`rfsh_ack_i` high while `rfsh_req_o` is 1) removes one. `rfsh_req_o` is 1 exactly when the count is nonzero. A due refresh and an acknowledge on the same edge leave the count unchanged.
- R7: `rfsh_urgent_o` is 1 exactly while the owed count is at least URGENT_AT (default 4). It is never 1 without `rfsh_req_o`.
- R8: The owed count saturates at DEBT_MAX (8). A refresh that falls due while the count is full and no acknowledge is taken sets `debt_err_o`. The count stays at 8, and `debt_err_o` stays 1 until reset.
- R9: Once `mem_ready_o` is 1 it stays 1 until reset. A new reset restarts the whole power-up and initialization sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| rfsh_ack_i | input | 1 | One-cycle acknowledge: the controller has issued one refresh |
| rfsh_req_o | output | 1 | A refresh is wanted (initialization or owed) |
| rfsh_urgent_o | output | 1 | Owed count at or above URGENT_AT; close the open page now |
| mem_ready_o | output | 1 | Initialization finished; normal accesses allowed |
| debt_err_o | output | 1 | Sticky: a refresh was lost because the owed count was full |

## Verification
The bench builds the block with CLK_HZ set to 1 MHz and leaves the retention and row parameters at their defaults. The power-up wait then shrinks to 200 cycles and the refresh interval to 15 cycles. With those values the full power-up, the eight-step burst, the climb of the owed count through the urgency threshold and past its cap of eight, and a second reset all fit in a few hundred cycles. Every edge is counted, so the boundary cycles can be checked exactly.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [1:0] {
    PH_PWRUP = 2'd0,
    PH_INIT  = 2'd1,
    PH_RUN   = 2'd2
  } rfsh_phase_e;

  // Power-up wait, rounded up so the quiet time is never shorter than asked.
  function automatic int unsigned wait_cycles(longint unsigned clk_hz,
                                              longint unsigned wait_us);
    longint unsigned prod;
    prod = clk_hz * wait_us;
    return int'((prod + 64'd999_999) / 64'd1_000_000);
  endfunction

  // Refresh spacing, rounded down so rows are refreshed no later than asked.
  function automatic int unsigned spacing_cycles(longint unsigned clk_hz,
                                                 longint unsigned retain_us,
                                                 longint unsigned rows);
    longint unsigned prod;
    longint unsigned res;
    prod = clk_hz * retain_us;
    res  = prod / (64'd1_000_000 * rows);
    if (res == 64'd0) res = 64'd1;
    return int'(res);
  endfunction

endpackage

// File: rtl/rfsh_tick_gen.sv
// Free-running period counter: pulses tick in the last cycle of each period.
module rfsh_tick_gen #(
  parameter int unsigned PERIOD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (en) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = en && !clr && (cnt_q == LAST);
endmodule

// File: rtl/rfsh_debt_ctr.sv
// Owed-refresh counter with saturation and sticky overflow flag.
module rfsh_debt_ctr #(
  parameter int unsigned DEBT_MAX = 8,
  localparam int unsigned DW = $clog2(DEBT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          due,
  input  logic          take,
  output logic [DW-1:0] debt_nxt,
  output logic          err_o
);
  localparam logic [DW-1:0] CAP = DW'(DEBT_MAX);

  logic [DW-1:0] debt_q;
  logic          err_q;
  logic          lost;

  always_comb begin
    lost     = 1'b0;
    debt_nxt = debt_q;
    if (clr) begin
      debt_nxt = '0;
    end else if (due && !take) begin
      if (debt_q == CAP) lost = 1'b1;
      else               debt_nxt = debt_q + 1'b1;
    end else if (take && !due) begin
      if (debt_q != '0) debt_nxt = debt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      debt_q <= '0;
      err_q  <= 1'b0;
    end else begin
      debt_q <= debt_nxt;
      if (lost) err_q <= 1'b1;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/dram_rfsh_sched.sv
module dram_rfsh_sched
  import dram_rfsh_pkg::*;
#(
  parameter longint unsigned CLK_HZ         = 100_000_000,
  parameter longint unsigned PWRUP_US       = 200,
  parameter longint unsigned RETAIN_US      = 16_000,
  parameter longint unsigned ROWS           = 1024,
  parameter int unsigned     INIT_REFRESHES = 8,
  parameter int unsigned     DEBT_MAX       = 8,
  parameter int unsigned     URGENT_AT      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rfsh_ack_i,
  output logic rfsh_req_o,
  output logic rfsh_urgent_o,
  output logic mem_ready_o,
  output logic debt_err_o
);
  localparam int unsigned PW_CYC = wait_cycles(CLK_HZ, PWRUP_US);
  localparam int unsigned IV_CYC = spacing_cycles(CLK_HZ, RETAIN_US, ROWS);
  localparam int unsigned IW     = $clog2(INIT_REFRESHES + 1);
  localparam int unsigned DW     = $clog2(DEBT_MAX + 1);
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_REFRESHES - 1);
  localparam logic [DW-1:0] URG_LVL   = DW'(URGENT_AT);

  rfsh_phase_e   phase_q;
  logic [IW-1:0] init_cnt_q;
  logic          req_q, urg_q, rdy_q;
  logic          pw_tick, iv_tick, taken;
  logic [DW-1:0] debt_nxt;

  assign taken = rfsh_ack_i && req_q;

  rfsh_tick_gen #(.PERIOD(PW_CYC)) u_pwrup_tmr (
    .clk  (clk),
    .rst  (rst),
    .clr  (phase_q != PH_PWRUP),
    .en   (phase_q == PH_PWRUP),
    .tick (pw_tick)
  );

  rfsh_tick_gen #(.PERIOD(IV_CYC)) u_iv_tmr (
    .clk  (clk),
    .rst  (rst),
    .clr  (phase_q != PH_RUN),
    .en   (phase_q == PH_RUN),
    .tick (iv_tick)
  );

  rfsh_debt_ctr #(.DEBT_MAX(DEBT_MAX)) u_debt (
    .clk      (clk),
    .rst      (rst),
    .clr      (phase_q != PH_RUN),
    .due      (iv_tick),
    .take     (taken && (phase_q == PH_RUN)),
    .debt_nxt (debt_nxt),
    .err_o    (debt_err_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_PWRUP;
      init_cnt_q <= '0;
      req_q      <= 1'b0;
      urg_q      <= 1'b0;
      rdy_q      <= 1'b0;
    end else begin
      case (phase_q)
        PH_PWRUP: begin
          if (pw_tick) begin
            phase_q <= PH_INIT;
            req_q   <= 1'b1;
          end
        end
        PH_INIT: begin
          if (taken) begin
            if (init_cnt_q == INIT_LAST) begin
              phase_q <= PH_RUN;
              req_q   <= 1'b0;
              rdy_q   <= 1'b1;
            end else begin
              init_cnt_q <= init_cnt_q + 1'b1;
            end
          end
        end
        PH_RUN: begin
          req_q <= (debt_nxt != '0);
          urg_q <= (debt_nxt >= URG_LVL);
        end
        default: phase_q <= PH_PWRUP;
      endcase
    end
  end

  assign rfsh_req_o    = req_q;
  assign rfsh_urgent_o = urg_q;
  assign mem_ready_o   = rdy_q;
endmodule

// File: rtl/dram_rfsh_sched_chk.sv
module dram_rfsh_sched_chk
  import dram_rfsh_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 100_000_000,
  parameter longint unsigned PWRUP_US = 200
) (
  input logic clk,
  input logic rst,
  input logic rfsh_ack_i,
  input logic rfsh_req_o,
  input logic rfsh_urgent_o,
  input logic mem_ready_o,
  input logic debt_err_o
);
  localparam int unsigned PW = wait_cycles(CLK_HZ, PWRUP_US);
  localparam int unsigned CW = $clog2(PW + 2);

  logic [CW-1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                    since_rst <= '0;
    else if (since_rst != CW'(PW)) since_rst <= since_rst + 1'b1;
  end

  p_wait_before_req_r2: assert property (@(posedge clk) disable iff (rst)
    rfsh_req_o |-> (since_rst == CW'(PW)));

  p_req_held_r3: assert property (@(posedge clk) disable iff (rst)
    (rfsh_req_o && !rfsh_ack_i) |=> rfsh_req_o);

  p_ready_after_ack_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_ready_o) |-> $past(rfsh_ack_i));

  p_req_drop_on_ack_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(rfsh_req_o) |-> $past(rfsh_ack_i));

  p_urgent_needs_req_r7: assert property (@(posedge clk) disable iff (rst)
    rfsh_urgent_o |-> rfsh_req_o);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    debt_err_o |=> debt_err_o);

  p_ready_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    mem_ready_o |=> mem_ready_o);
endmodule

bind dram_rfsh_sched dram_rfsh_sched_chk #(
  .CLK_HZ  (CLK_HZ),
  .PWRUP_US(PWRUP_US)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rfsh_ack_i   (rfsh_ack_i),
  .rfsh_req_o   (rfsh_req_o),
  .rfsh_urgent_o(rfsh_urgent_o),
  .mem_ready_o  (mem_ready_o),
  .debt_err_o   (debt_err_o)
);

// File: tb/dram_rfsh_sched_bench.sv
module dram_rfsh_sched_bench;
  localparam longint unsigned TB_HZ = 1_000_000;
  localparam int PW = int'((TB_HZ * 200 + 999_999) / 1_000_000);   // 200
  localparam int IV = int'((TB_HZ * 16_000) / (1_000_000 * 1024)); // 15

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ack = 1'b0;
  logic req, urg, rdy, err;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dram_rfsh_sched #(.CLK_HZ(TB_HZ)) u_dram_rfsh_sched (
    .clk(clk), .rst(rst), .rfsh_ack_i(ack),
    .rfsh_req_o(req), .rfsh_urgent_o(urg),
    .mem_ready_o(rdy), .debt_err_o(err)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack_for(int n);
    ack = 1'b1;
    step(n);
    ack = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    step(3);
    chk("R1 req in reset", req, 1'b0);
    chk("R1 ready in reset", rdy, 1'b0);
    chk("R1 err in reset", err, 1'b0);
    rst = 1'b0;
    step(1);
    chk("R1 req after release", req, 1'b0);
    chk("R1 urgent after release", urg, 1'b0);
    chk("R9 ready cleared by reset", rdy, 1'b0);
  endtask

  // Enters one edge after release (from t_reset).
  task automatic t_powerup;
    ack_for(5);             // R4: ignored while no request
    step(PW - 1 - 6);
    chk("R2 req low at edge PW-1", req, 1'b0);
    chk("R4 early ack ignored", req, 1'b0);
    step(1);
    chk("R2 req high at edge PW", req, 1'b1);
  endtask

  task automatic t_init;
    for (int i = 0; i < 7; i++) begin
      ack_for(1);
      step(2);
      chk("R3 req held in burst", req, 1'b1);
      chk("R3 not ready mid burst", rdy, 1'b0);
    end
    ack_for(1);
    chk("R3 ready after eighth ack", rdy, 1'b1);
    chk("R3 req drops after eighth ack", req, 1'b0);
  endtask

  // k counts edges since the eighth init ack.
  task automatic t_interval;
    ack_for(3);                       // R4: no debt, must be ignored
    step(IV - 1 - 3);                 // k = IV-1
    chk("R5 no refresh before interval", req, 1'b0);
    step(1);                          // k = IV
    chk("R5 refresh due at interval", req, 1'b1);
    chk("R4 acks with no debt not banked", req, 1'b1);
    chk("R7 no urgency at one owed", urg, 1'b0);
    ack_for(1);                       // k = IV+1
    chk("R6 ack clears single owed", req, 1'b0);
  endtask

  task automatic t_same_edge;
    step(IV - 1);                     // k = 2IV
    chk("R6 owed one", req, 1'b1);
    step(IV - 1);                     // k = 3IV-1
    ack_for(1);                       // k = 3IV, due and ack together
    chk("R6 due+ack leaves count", req, 1'b1);
    ack_for(1);                       // k = 3IV+1
    chk("R6 count back to zero", req, 1'b0);
  endtask

  task automatic t_urgent;
    step(IV - 1);                     // k = 4IV, owed 1
    step(2 * IV);                     // k = 6IV, owed 3
    chk("R7 not urgent at three", urg, 1'b0);
    chk("R6 req with three owed", req, 1'b1);
    step(IV);                         // k = 7IV, owed 4
    chk("R7 urgent at threshold", urg, 1'b1);
    ack_for(1);                       // owed 3
    chk("R7 urgency clears below threshold", urg, 1'b0);
  endtask

  task automatic t_overflow;
    step(5 * IV - 1);                 // k = 12IV, owed 8
    chk("R8 no error at cap", err, 1'b0);
    step(IV);                         // k = 13IV, one lost
    chk("R8 error on lost refresh", err, 1'b1);
    ack_for(7);
    chk("R8 count held at cap", req, 1'b1);
    ack_for(1);
    chk("R8 cap drains in eight acks", req, 1'b0);
    chk("R7 urgency gone when drained", urg, 1'b0);
    chk("R8 error sticky", err, 1'b1);
    chk("R9 ready sticky", rdy, 1'b1);
  endtask

  initial begin
    t_reset;
    t_powerup;
    t_init;
    t_interval;
    t_same_edge;
    t_urgent;
    t_overflow;
    t_reset;
    chk("R9 error cleared by reset", err, 1'b0);
    t_powerup;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20_000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule